// File: doc/BRIEF.md
# Frame Buffer Flip Scheduler

This block holds the pair of addresses that a display fetch engine scans out of: the first byte of the frame and its end (ceiling). A requester hands it a new frame start address, the line pitch in bytes and the number of visible lines. The block derives the ceiling and then decides when the new pair may take effect, so that a swap never lands right before a vertical blank.

A microsecond timer counts `us_tick` pulses since the last end-of-frame, or since the raster was switched on. If at least the safety window (1000 us by default) is left before the next blank, the new pair is written at once. If less is left, or the frame period has already run out, the pair is parked. It is then written on the next end-of-frame. Each accepted request leaves one completion event outstanding, and a second request made in that time is refused. The completion pulse for a parked flip is held back by one frame, so it reports the frame that actually showed the new buffer.

Top module: `flip_scheduler`

## Requirements
- R1: While `rst_n` is low and after its release, `scan_base` and `scan_ceil` read 0 and `flip_pending`, `flip_busy`, `flip_done` and `req_rejected` read 0.
- R2: The ceiling written with a request is `req_base + req_pitch * req_lines`, taken modulo 2^AW, when `legacy_mode` is 0. It is one less than that value, making it an inclusive last address, when `legacy_mode` is 1.
- R3: `scan_base` and `scan_ceil` only ever change on the same clock edge as each other. That edge comes right after an accepted immediate request, or right after an end-of-frame that releases a parked pair.
- R4: The elapsed count adds one per `us_tick` while `raster_en` is high. It is held at 0 while `raster_en` is low and cleared by `eof`. A request is written immediately when elapsed + SAFE_US <= `frame_period_us`, and is parked otherwise, which includes the case where elapsed has passed the frame period.
- R5: A parked request raises `flip_pending` and leaves `scan_base` and `scan_ceil` unchanged. On the next `eof` the parked pair is written and `flip_pending` falls.
- R6: An accepted request sets `flip_busy`. `flip_done` pulses for one cycle after an `eof` that finds `flip_busy` set and no parked pair, and `flip_busy` then clears. An `eof` that writes a parked pair gives no pulse, so that flip completes on the following `eof`.
- R7: A request made while a flip is outstanding pulses `req_rejected` one cycle later. It changes neither the addresses nor `flip_pending` nor `flip_busy`.
- R8: When `req_valid` and `eof` arrive in the same cycle, the end-of-frame is handled first. The request is then judged with an elapsed time of 0 and with the busy state that the end-of-frame left behind.

Parameters: AW (address width, default 32), PW (pitch width, default 16), LW (line-count width, default 12), TW (timer width, default 20), SAFE_US (safety window in microseconds, default 1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| raster_en | input | 1 | Raster running; the timer is held at 0 while low |
| eof | input | 1 | End-of-frame pulse |
| frame_period_us | input | TW | Frame period in microseconds |
| legacy_mode | input | 1 | 1: the ceiling is an inclusive last address |
| req_valid | input | 1 | Flip request strobe |
| req_base | input | AW | Frame start address |
| req_pitch | input | PW | Line pitch in bytes |
| req_lines | input | LW | Visible line count |
| scan_base | output | AW | Current scan-out start address |
| scan_ceil | output | AW | Current scan-out ceiling address |
| flip_pending | output | 1 | A parked pair waits for end-of-frame |
| flip_busy | output | 1 | A flip completion is still outstanding |
| flip_done | output | 1 | One-cycle flip completion pulse |
| req_rejected | output | 1 | One-cycle pulse for a refused request |

## Verification
Requests are placed at several points in a frame: just after an end-of-frame, which gives an immediate write, and well into it, which parks the pair. They are also placed with the raster switched off, and after the frame period has run out with no end-of-frame. Together these separate the two outcomes of the window comparison and show that the timer is held while the raster is off. A request issued during an outstanding flip shows the refusal path. A request landing in the same cycle as an end-of-frame shows the ordering: a wrong order would either refuse it or park it. Running with `legacy_mode` set and cleared separates the inclusive ceiling from the exclusive one. A behavioural model checks every output on every cycle.

// File: rtl/flip_sched_pkg.sv
package flip_sched_pkg;

  // Outcome of evaluating one flip request.
  typedef enum logic [1:0] {
    DEC_NONE   = 2'd0,
    DEC_NOW    = 2'd1,
    DEC_DEFER  = 2'd2,
    DEC_REJECT = 2'd3
  } flip_dec_e;

endpackage

// File: rtl/fs_frame_timer.sv
// Microsecond count since the last end-of-frame or raster enable,
// and the safety-window decision against the programmed frame period.
module fs_frame_timer #(
  parameter int TW      = 20,
  parameter int SAFE_US = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raster_en,
  input  logic          eof,
  input  logic          us_tick,
  input  logic [TW-1:0] frame_period_us,
  output logic          window_ok
);

  localparam int CW = TW + 2;
  localparam logic [TW-1:0] EL_MAX  = {TW{1'b1}};
  localparam logic [CW-1:0] SAFE_CW = CW'(SAFE_US);

  logic [TW-1:0] elapsed_q, elapsed_d;
  logic          elapsed_en;
  logic [TW-1:0] elapsed_eff;
  logic [CW-1:0] reach;

  // Next-state: clear on end-of-frame or while the raster is off,
  // otherwise count ticks with saturation.
  always_comb begin
    elapsed_en = 1'b0;
    elapsed_d  = elapsed_q;
    if (!raster_en || eof) begin
      elapsed_en = 1'b1;
      elapsed_d  = '0;
    end else if (us_tick && (elapsed_q != EL_MAX)) begin
      elapsed_en = 1'b1;
      elapsed_d  = elapsed_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (elapsed_en) begin
      elapsed_q <= elapsed_d;
    end
  end

  // End-of-frame is taken first: a request in the same cycle sees zero.
  always_comb begin
    elapsed_eff = eof ? '0 : elapsed_q;
    reach       = CW'(elapsed_eff) + SAFE_CW;
    window_ok   = (reach <= CW'(frame_period_us));
  end

endmodule

// File: rtl/fs_span_calc.sv
// Ceiling address from start, pitch and visible lines.
module fs_span_calc #(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int LW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] pitch,
  input  logic [LW-1:0] lines,
  input  logic          inclusive,
  output logic [AW-1:0] ceil
);

  localparam int MW = PW + LW;

  logic [MW-1:0] span_full;
  logic [AW-1:0] span;

  always_comb begin
    span_full = MW'(pitch) * MW'(lines);
    span      = AW'(span_full);
    ceil      = base + span - AW'(inclusive);
  end

endmodule

// File: rtl/fs_flip_ctrl.sv
// Commit / defer / reject decision and the registered address pair.
module fs_flip_ctrl
  import flip_sched_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eof,
  input  logic          req_valid,
  input  logic          window_ok,
  input  logic [AW-1:0] new_base,
  input  logic [AW-1:0] new_ceil,
  output logic [AW-1:0] scan_base,
  output logic [AW-1:0] scan_ceil,
  output logic          pending,
  output logic          busy,
  output logic          done,
  output logic          rejected
);

  logic [AW-1:0] base_q, ceil_q, base_d, ceil_d;
  logic [AW-1:0] pbase_q, pceil_q;
  logic          pend_q, pend_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          rej_q, rej_d;
  logic          busy_after_eof;
  logic          release_pend;
  logic          pair_we, park_we;
  flip_dec_e     dec;

  // Step 1: end-of-frame handling.
  always_comb begin
    release_pend   = eof && pend_q;
    busy_after_eof = busy_q;
    done_d         = 1'b0;
    if (eof && !pend_q && busy_q) begin
      done_d         = 1'b1;
      busy_after_eof = 1'b0;
    end
  end

  // Step 2: request evaluation against the post-eof state.
  always_comb begin
    if (!req_valid)          dec = DEC_NONE;
    else if (busy_after_eof) dec = DEC_REJECT;
    else if (window_ok)      dec = DEC_NOW;
    else                     dec = DEC_DEFER;
  end

  // Next-state for the pair, the parking slot and the flags.
  always_comb begin
    pair_we = (dec == DEC_NOW) || release_pend;
    park_we = (dec == DEC_DEFER);
    base_d  = (dec == DEC_NOW) ? new_base : pbase_q;
    ceil_d  = (dec == DEC_NOW) ? new_ceil : pceil_q;
    pend_d  = park_we ? 1'b1 : (release_pend ? 1'b0 : pend_q);
    busy_d  = ((dec == DEC_NOW) || (dec == DEC_DEFER)) ? 1'b1 : busy_after_eof;
    rej_d   = (dec == DEC_REJECT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ceil_q <= '0;
    end else if (pair_we) begin
      base_q <= base_d;
      ceil_q <= ceil_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbase_q <= '0;
      pceil_q <= '0;
    end else if (park_we) begin
      pbase_q <= new_base;
      pceil_q <= new_ceil;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      done_q <= done_d;
      rej_q  <= rej_d;
    end
  end

  assign scan_base = base_q;
  assign scan_ceil = ceil_q;
  assign pending   = pend_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign rejected  = rej_q;

endmodule

// File: rtl/flip_scheduler.sv
module flip_scheduler #(
  parameter int AW      = 32,
  parameter int PW      = 16,
  parameter int LW      = 12,
  parameter int TW      = 20,
  parameter int SAFE_US = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic          raster_en,
  input  logic          eof,
  input  logic [TW-1:0] frame_period_us,
  input  logic          legacy_mode,
  input  logic          req_valid,
  input  logic [AW-1:0] req_base,
  input  logic [PW-1:0] req_pitch,
  input  logic [LW-1:0] req_lines,
  output logic [AW-1:0] scan_base,
  output logic [AW-1:0] scan_ceil,
  output logic          flip_pending,
  output logic          flip_busy,
  output logic          flip_done,
  output logic          req_rejected
);

  logic          window_ok;
  logic [AW-1:0] new_ceil;

  fs_frame_timer #(.TW(TW), .SAFE_US(SAFE_US)) i_timer (
    .clk             (clk),
    .rst_n           (rst_n),
    .raster_en       (raster_en),
    .eof             (eof),
    .us_tick         (us_tick),
    .frame_period_us (frame_period_us),
    .window_ok       (window_ok)
  );

  fs_span_calc #(.AW(AW), .PW(PW), .LW(LW)) i_span (
    .base      (req_base),
    .pitch     (req_pitch),
    .lines     (req_lines),
    .inclusive (legacy_mode),
    .ceil      (new_ceil)
  );

  fs_flip_ctrl #(.AW(AW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .eof       (eof),
    .req_valid (req_valid),
    .window_ok (window_ok),
    .new_base  (req_base),
    .new_ceil  (new_ceil),
    .scan_base (scan_base),
    .scan_ceil (scan_ceil),
    .pending   (flip_pending),
    .busy      (flip_busy),
    .done      (flip_done),
    .rejected  (req_rejected)
  );

endmodule

// File: rtl/flip_scheduler_checker.sv
module flip_scheduler_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eof,
  input logic          req_valid,
  input logic [AW-1:0] scan_base,
  input logic [AW-1:0] scan_ceil,
  input logic          flip_pending,
  input logic          flip_busy,
  input logic          flip_done,
  input logic          req_rejected
);

  // R3: the pair moves only after a request or an end-of-frame
  a_r3_pair_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((scan_base != $past(scan_base)) || (scan_ceil != $past(scan_ceil)))
      |-> ($past(req_valid) || $past(eof)));

  // R5: a parked pair always has an outstanding flip
  a_r5_pending_busy: assert property (@(posedge clk) disable iff (!rst_n)
    flip_pending |-> flip_busy);

  // R5: parking starts only from a request
  a_r5_park_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flip_pending) |-> $past(req_valid));

  // R5: parking ends only at an end-of-frame
  a_r5_release_eof: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flip_pending) |-> $past(eof));

  // R6: completion follows an end-of-frame with a flip outstanding
  a_r6_done_eof: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |-> ($past(eof) && $past(flip_busy) && !$past(flip_pending)));

  // R7: refusal only while busy, and it leaves the pending flag alone
  a_r7_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_rejected |-> ($past(flip_busy) && $past(req_valid)));

  a_r7_reject_excl: assert property (@(posedge clk) disable iff (!rst_n)
    req_rejected |-> !(flip_done && !flip_busy) || $past(eof));

endmodule

bind flip_scheduler flip_scheduler_checker #(.AW(AW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eof          (eof),
  .req_valid    (req_valid),
  .scan_base    (scan_base),
  .scan_ceil    (scan_ceil),
  .flip_pending (flip_pending),
  .flip_busy    (flip_busy),
  .flip_done    (flip_done),
  .req_rejected (req_rejected)
);

// File: tb/test_flip_scheduler.sv
module test_flip_scheduler;

  localparam int CLK_NS = 10;
  localparam int AW = 32, PW = 16, LW = 12, TW = 20, SAFE = 1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          us_tick = 1'b0;
  logic          raster_en = 1'b0;
  logic          eof = 1'b0;
  logic [TW-1:0] frame_period_us = '0;
  logic          legacy_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [PW-1:0] req_pitch = '0;
  logic [LW-1:0] req_lines = '0;
  logic [AW-1:0] scan_base, scan_ceil;
  logic          flip_pending, flip_busy, flip_done, req_rejected;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit started  = 0;

  // Behavioural reference state
  logic [AW-1:0] m_base = '0, m_ceil = '0, m_pbase = '0, m_pceil = '0;
  bit   m_pend = 0, m_busy = 0, m_done = 0, m_rej = 0;
  int   m_el = 0;

  always #(CLK_NS/2) clk = ~clk;

  flip_scheduler i_flip_scheduler (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .raster_en(raster_en),
    .eof(eof), .frame_period_us(frame_period_us), .legacy_mode(legacy_mode),
    .req_valid(req_valid), .req_base(req_base), .req_pitch(req_pitch),
    .req_lines(req_lines), .scan_base(scan_base), .scan_ceil(scan_ceil),
    .flip_pending(flip_pending), .flip_busy(flip_busy),
    .flip_done(flip_done), .req_rejected(req_rejected)
  );

  function automatic logic [AW-1:0] exp_ceil(logic [AW-1:0] b, int p, int l, bit inc);
    longint s;
    s = longint'(b) + longint'(p) * longint'(l) - (inc ? 1 : 0);
    return s[AW-1:0];
  endfunction

  task automatic check(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Microsecond tick every second cycle
  always @(negedge clk) us_tick <= ~us_tick;

  // Reference model, updated on each edge from inputs held since the last negedge
  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (!rst_n) begin
      m_base = '0; m_ceil = '0; m_pbase = '0; m_pceil = '0;
      m_pend = 0; m_busy = 0; m_done = 0; m_rej = 0; m_el = 0;
    end else begin
      int  eff;
      bit  busy_now;
      eff = eof ? 0 : m_el;
      busy_now = m_busy;
      m_done = 0;
      m_rej  = 0;
      if (eof) begin
        if (m_pend) begin
          m_base = m_pbase; m_ceil = m_pceil; m_pend = 0;
        end else if (m_busy) begin
          m_done = 1; busy_now = 0;
        end
      end
      if (req_valid) begin
        if (busy_now) m_rej = 1;
        else begin
          if (eff + SAFE <= int'(frame_period_us)) begin
            m_base = req_base;
            m_ceil = exp_ceil(req_base, int'(req_pitch), int'(req_lines), legacy_mode);
          end else begin
            m_pbase = req_base;
            m_pceil = exp_ceil(req_base, int'(req_pitch), int'(req_lines), legacy_mode);
            m_pend = 1;
          end
          busy_now = 1;
        end
      end
      m_busy = busy_now;
      if (!raster_en || eof) m_el = 0;
      else if (us_tick && m_el < (1 << TW) - 1) m_el++;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      check(scan_base == m_base, "R3 scan_base", scan_base, m_base);
      check(scan_ceil == m_ceil, "R2 scan_ceil", scan_ceil, m_ceil);
      check(flip_pending == m_pend, "R5 flip_pending", AW'(flip_pending), AW'(m_pend));
      check(flip_busy == m_busy, "R6 flip_busy", AW'(flip_busy), AW'(m_busy));
      check(flip_done == m_done, "R6 flip_done", AW'(flip_done), AW'(m_done));
      check(req_rejected == m_rej, "R7 req_rejected", AW'(req_rejected), AW'(m_rej));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic do_req(logic [AW-1:0] b, int p, int l, bit with_eof);
    @(negedge clk);
    req_valid = 1'b1; req_base = b; req_pitch = PW'(p); req_lines = LW'(l);
    eof = with_eof;
    @(negedge clk);
    req_valid = 1'b0; eof = 1'b0;
  endtask

  task automatic pulse_eof();
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scan_base == '0 && scan_ceil == '0, "R1 pair after reset", scan_base, '0);
    check(!flip_pending && !flip_busy && !flip_done && !req_rejected,
          "R1 flags after reset", AW'({flip_pending, flip_busy, flip_done, req_rejected}), '0);
    rst_n = 1'b1;
    frame_period_us = TW'(1200);
    @(negedge clk); raster_en = 1'b1;

    // Immediate commit just after enable (R2, R3, R4)
    do_req(32'h1000_0000, 2560, 480, 0);
    check(scan_base == 32'h1000_0000, "R3 immediate base", scan_base, 32'h1000_0000);
    check(scan_ceil == exp_ceil(32'h1000_0000, 2560, 480, 0), "R2 exclusive ceil",
          scan_ceil, exp_ceil(32'h1000_0000, 2560, 480, 0));

    // Overlapping request refused (R7)
    do_req(32'h2000_0000, 2560, 480, 0);
    check(req_rejected == 1'b1, "R7 reject pulse", AW'(req_rejected), 1);
    check(scan_base == 32'h1000_0000, "R7 pair unchanged", scan_base, 32'h1000_0000);

    // Completion at end-of-frame (R6)
    pulse_eof();
    check(flip_done == 1'b1 && flip_busy == 1'b0, "R6 done at eof",
          AW'({flip_done, flip_busy}), 32'h2);

    // Late request parks (R5)
    repeat (600) @(negedge clk);
    do_req(32'h3000_0000, 1280, 720, 0);
    check(flip_pending == 1'b1, "R5 parked", AW'(flip_pending), 1);
    check(scan_base == 32'h1000_0000, "R5 pair held", scan_base, 32'h1000_0000);
    pulse_eof();
    check(scan_base == 32'h3000_0000 && !flip_pending, "R5 released at eof", scan_base, 32'h3000_0000);
    check(flip_done == 1'b0, "R6 done held back", AW'(flip_done), 0);
    repeat (10) @(negedge clk);
    pulse_eof();
    check(flip_done == 1'b1, "R6 deferred done", AW'(flip_done), 1);

    // Inclusive ceiling (R2)
    legacy_mode = 1'b1;
    do_req(32'h4000_0100, 64, 3, 0);
    check(scan_ceil == 32'h4000_01BF, "R2 inclusive ceil", scan_ceil, 32'h4000_01BF);

    // Request and eof in one cycle while busy and late in the frame (R8)
    repeat (600) @(negedge clk);
    do_req(32'h5000_0000, 100, 10, 1);
    check(flip_done == 1'b1 && scan_base == 32'h5000_0000 && !flip_pending,
          "R8 eof first then commit", scan_base, 32'h5000_0000);
    pulse_eof();
    legacy_mode = 1'b0;

    // Raster off holds the timer, so commit is immediate (R4)
    @(negedge clk); raster_en = 1'b0;
    repeat (3000) @(negedge clk);
    do_req(32'h6000_0000, 16, 16, 0);
    check(scan_base == 32'h6000_0000 && !flip_pending, "R4 raster off immediate",
          scan_base, 32'h6000_0000);
    pulse_eof();

    // Frame period overrun parks (R4)
    @(negedge clk); raster_en = 1'b1;
    repeat (3000) @(negedge clk);
    do_req(32'h7000_0000, 16, 16, 0);
    check(flip_pending == 1'b1 && scan_base == 32'h6000_0000, "R4 overrun parks",
          scan_base, 32'h6000_0000);
    pulse_eof();
    check(scan_base == 32'h7000_0000, "R5 overrun release", scan_base, 32'h7000_0000);
    pulse_eof();
    check(flip_done == 1'b1, "R6 overrun done", AW'(flip_done), 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule